// File: doc/BRIEF.md
# Light-Load Conduction Mode Selector

This block picks the conduction mode of one synchronous buck channel. Once per switching cycle, just before the high-side switch turns on, the power stage supplies a strobe and the sampled sign of the voltage across the synchronous switch. A positive sign means the load current is below the critical inductor current. A negative sign means it is above. The selector runs the channel in fixed-frequency continuous-conduction PWM (CCM) or in hysteretic diode-emulation mode (HYS). It changes mode only after an unbroken run of eight samples that all call for the other mode, so the mode cannot chatter.

Three conditions hold the channel in CCM and clear any run in progress: the forced-CCM strap, an unfinished soft-start, and dual-rail memory mode when this instance serves the tracking channel. The tracking channel must be able to sink current at every load. In HYS the PWM/error-amplifier path is disabled and the lower switch acts as a diode emulator. The selector then produces the high-side request from the two hysteresis comparator outputs. It also withholds permission for the lower switch while that request is high.

Top module: `cond_mode_sel`

## Requirements
- R1: After a synchronous reset the outputs are `mode_hys`=0, `pwm_en`=1, `diode_em_en`=0, `hs_req`=0 and `ls_permit`=1.
- R2: A sign value counts only in a cycle where `cyc_strobe`=1. `sw_sign_pos`=1 votes for HYS and 0 votes for CCM. Sign changes without a strobe have no effect.
- R3: From CCM, eight consecutive strobed samples with `sw_sign_pos`=1 switch the mode to HYS. `mode_hys` rises in the cycle after the clock edge that takes the eighth sample.
- R4: From HYS, eight consecutive strobed samples with `sw_sign_pos`=0 switch the mode back to CCM, with the same timing as R3.
- R5: A strobed sample that votes for the current mode clears the run, and a mode change also clears it. Runs shorter than eight never change the mode.
- R6: While `force_ccm`=1 the mode is CCM from the next cycle on, and the run is cleared.
- R7: While `ss_done`=0 the mode is CCM from the next cycle on, and the run is cleared.
- R8: When `ddr_mode`=1 and `chan_idx` equals the tracking index (1), the block behaves as in R6. With `chan_idx`=0, `ddr_mode` has no effect.
- R9: `pwm_en` is 1 exactly in CCM and `diode_em_en` is 1 exactly in HYS.
- R10: `hs_req` is registered. Each clock edge sets it to 0 if the mode after that edge is CCM or if `hys_above_hi`=1. Otherwise the edge sets it to 1 if `hys_below_lo`=1, and holds it if not.
- R11: `ls_permit` is 0 exactly when `hs_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_strobe | input | 1 | One-cycle pulse per switching cycle, before high-side turn-on |
| sw_sign_pos | input | 1 | Sampled synchronous-switch voltage sign, 1 = positive (below critical) |
| force_ccm | input | 1 | Strap that forbids hysteretic operation |
| ss_done | input | 1 | Soft-start complete |
| ddr_mode | input | 1 | Dual-rail memory supply mode |
| chan_idx | input | 1 | Channel index of this instance |
| hys_below_lo | input | 1 | Output below the lower hysteresis threshold |
| hys_above_hi | input | 1 | Output above the upper hysteresis threshold |
| mode_hys | output | 1 | 1 = hysteretic mode, 0 = CCM |
| pwm_en | output | 1 | PWM comparator and error-amplifier enable |
| diode_em_en | output | 1 | Lower-switch diode-emulation enable |
| hs_req | output | 1 | Hysteretic high-side pulse request |
| ls_permit | output | 1 | Lower switch may be driven |

## Verification
Two events can fall in the same clock edge. The eighth sample of a run can coincide with an inhibit condition (strap, soft-start or tracking-channel memory mode). In that case the inhibit must win and the mode must stay CCM. The sample that returns the mode to CCM can also coincide with the lower-threshold comparator. In that case `hs_req` must fall rather than set. Directed sequences build seven-sample runs and then apply the eighth sample together with the competing input. Random stimulus raises the same collisions many more times. The bench compares every output each cycle with its own model of the requirements.

// File: rtl/cms_pkg.sv
package cms_pkg;

    typedef enum logic {
        MODE_CCM = 1'b0,
        MODE_HYS = 1'b1
    } cmode_e;

    typedef struct packed {
        logic strobe;
        logic below_crit;
    } cyc_sample_t;

    function automatic cmode_e vote_of(input logic below_crit);
        return below_crit ? MODE_HYS : MODE_CCM;
    endfunction

endpackage

// File: rtl/cms_run_qual.sv
module cms_run_qual
    import cms_pkg::*;
#(
    parameter int RUN_LEN = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        inhibit,
    input  cyc_sample_t smp,
    output cmode_e      mode_q,
    output cmode_e      mode_d
);
    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    logic [CW-1:0] cnt_q, cnt_d;
    cmode_e        want;

    always_comb begin
        want   = vote_of(smp.below_crit);
        mode_d = mode_q;
        cnt_d  = cnt_q;
        if (inhibit) begin
            mode_d = MODE_CCM;
            cnt_d  = '0;
        end else if (smp.strobe) begin
            if (want == mode_q) begin
                cnt_d = '0;
            end else if (cnt_q == LAST) begin
                mode_d = want;
                cnt_d  = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_CCM;
            cnt_q  <= '0;
        end else begin
            mode_q <= mode_d;
            cnt_q  <= cnt_d;
        end
    end

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    assert_inhibit_ccm_R6: assert property (@(posedge clk) disable iff (rst)
        inhibit |=> (mode_q == MODE_CCM) && (cnt_q == '0));

    assert_flip_needs_run_R3: assert property (@(posedge clk) disable iff (rst)
        ((mode_q != $past(mode_q)) && !$past(inhibit))
            |-> ($past(smp.strobe) && ($past(cnt_q) == LAST)));

endmodule

// File: rtl/cms_hys_gate.sv
module cms_hys_gate (
    input  logic clk,
    input  logic rst,
    input  logic hys_next,
    input  logic below_lo,
    input  logic above_hi,
    output logic hs_q
);
    logic hs_d;

    always_comb begin
        if (!hys_next || above_hi) hs_d = 1'b0;
        else if (below_lo)         hs_d = 1'b1;
        else                       hs_d = hs_q;
    end

    always_ff @(posedge clk) begin
        if (rst) hs_q <= 1'b0;
        else     hs_q <= hs_d;
    end

    assert_hs_set_R10: assert property (@(posedge clk) disable iff (rst)
        (hys_next && below_lo && !above_hi) |=> hs_q);

    assert_hs_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (above_hi || !hys_next) |=> !hs_q);

endmodule

// File: rtl/cond_mode_sel.sv
module cond_mode_sel
    import cms_pkg::*;
#(
    parameter int RUN_LEN    = 8,
    parameter int TRACK_CHAN = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_strobe,
    input  logic sw_sign_pos,
    input  logic force_ccm,
    input  logic ss_done,
    input  logic ddr_mode,
    input  logic chan_idx,
    input  logic hys_below_lo,
    input  logic hys_above_hi,
    output logic mode_hys,
    output logic pwm_en,
    output logic diode_em_en,
    output logic hs_req,
    output logic ls_permit
);
    localparam logic TRACK_BIT = 1'(TRACK_CHAN);

    cyc_sample_t smp;
    cmode_e      mode_q, mode_d;
    logic        inhibit;
    logic        hs_q;

    assign smp.strobe     = cyc_strobe;
    assign smp.below_crit = sw_sign_pos;
    assign inhibit = !ss_done || force_ccm || (ddr_mode && (chan_idx == TRACK_BIT));

    cms_run_qual #(.RUN_LEN(RUN_LEN)) u_qual (
        .clk     (clk),
        .rst     (rst),
        .inhibit (inhibit),
        .smp     (smp),
        .mode_q  (mode_q),
        .mode_d  (mode_d)
    );

    cms_hys_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .hys_next (mode_d == MODE_HYS),
        .below_lo (hys_below_lo),
        .above_hi (hys_above_hi),
        .hs_q     (hs_q)
    );

    assign mode_hys    = (mode_q == MODE_HYS);
    assign pwm_en      = (mode_q == MODE_CCM);
    assign diode_em_en = (mode_q == MODE_HYS);
    assign hs_req      = hs_q;
    assign ls_permit   = !hs_q;

    assert_hs_only_hys_R10: assert property (@(posedge clk) disable iff (rst)
        hs_req |-> mode_hys);

    assert_no_overlap_R11: assert property (@(posedge clk) disable iff (rst)
        !(hs_req && ls_permit));

    assert_path_excl_R9: assert property (@(posedge clk) disable iff (rst)
        pwm_en != diode_em_en);

    assert_ddr_track_R8: assert property (@(posedge clk) disable iff (rst)
        (ddr_mode && chan_idx == TRACK_BIT) |=> !mode_hys);

endmodule

// File: tb/tb_cond_mode_sel.sv
`timescale 1ns/1ps
module tb_cond_mode_sel;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cyc_strobe = 0, sw_sign_pos = 0, force_ccm = 0, ss_done = 0;
    logic ddr_mode = 0, chan_idx = 0, hys_below_lo = 0, hys_above_hi = 0;
    logic mode_hys, pwm_en, diode_em_en, hs_req, ls_permit;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference state (value after the most recent clock edge)
    bit m_hys = 0;
    int m_cnt = 0;
    bit m_hs  = 0;

    always #2 clk = ~clk;

    cond_mode_sel dut (
        .clk(clk), .rst(rst), .cyc_strobe(cyc_strobe), .sw_sign_pos(sw_sign_pos),
        .force_ccm(force_ccm), .ss_done(ss_done), .ddr_mode(ddr_mode),
        .chan_idx(chan_idx), .hys_below_lo(hys_below_lo), .hys_above_hi(hys_above_hi),
        .mode_hys(mode_hys), .pwm_en(pwm_en), .diode_em_en(diode_em_en),
        .hs_req(hs_req), .ls_permit(ls_permit)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_inhibit(bit ssd, bit fc, bit ddr, bit ch);
        return !ssd || fc || (ddr && ch);
    endfunction

    // advance the model by one clock edge using the present inputs
    task automatic model_edge();
        bit nh;
        nh = m_hys;
        if (exp_inhibit(ss_done, force_ccm, ddr_mode, chan_idx)) begin
            nh = 0; m_cnt = 0;
        end else if (cyc_strobe) begin
            if (sw_sign_pos == m_hys) m_cnt = 0;
            else if (m_cnt == 7) begin nh = sw_sign_pos; m_cnt = 0; end
            else m_cnt++;
        end
        if (!nh || hys_above_hi) m_hs = 0;
        else if (hys_below_lo)   m_hs = 1;
        m_hys = nh;
    endtask

    task automatic compare(input string mode_tag);
        chk(mode_hys == m_hys, mode_tag, mode_hys, m_hys);
        chk(pwm_en == !m_hys && diode_em_en == m_hys, "R9", {pwm_en, diode_em_en}, {!m_hys, m_hys});
        chk(hs_req == m_hs, "R10", hs_req, m_hs);
        chk(ls_permit == !m_hs, "R11", ls_permit, !m_hs);
    endtask

    // at a falling edge: check outputs, drive new inputs, move the model, wait
    task automatic step(input string tag, input bit st, input bit sg, input bit fc,
                        input bit ssd, input bit ddr, input bit ch, input bit lo, input bit hi);
        compare(tag);
        cyc_strobe = st; sw_sign_pos = sg; force_ccm = fc; ss_done = ssd;
        ddr_mode = ddr; chan_idx = ch; hys_below_lo = lo; hys_above_hi = hi;
        model_edge();
        @(negedge clk);
    endtask

    task automatic run_samples(input string tag, input int n, input bit sg);
        for (int i = 0; i < n; i++) step(tag, 1, sg, 0, 1, 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed;
        bit regime;
        seed = 1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk(mode_hys == 0 && pwm_en == 1 && diode_em_en == 0 && hs_req == 0 && ls_permit == 1,
            "R1", {mode_hys, pwm_en, diode_em_en, hs_req, ls_permit}, 5'b01001);

        // R2: sign changes without strobe are ignored
        for (int i = 0; i < 20; i++) step("R2", 0, 1, 0, 1, 0, 0, 0, 0);
        // R5: seven samples, a breaking sample, seven more: no change
        run_samples("R5", 7, 1);
        run_samples("R5", 1, 0);
        run_samples("R5", 7, 1);
        // R3: eighth sample enters hysteretic mode
        run_samples("R3", 1, 1);
        step("R3", 0, 1, 0, 1, 0, 0, 0, 0);
        chk(mode_hys == 1, "R3", mode_hys, 1);
        // R10: set, hold, clear, both high clears
        step("R10", 0, 1, 0, 1, 0, 0, 1, 0);
        step("R10", 0, 1, 0, 1, 0, 0, 0, 0);
        chk(hs_req == 1, "R10", hs_req, 1);
        step("R10", 0, 1, 0, 1, 0, 0, 0, 1);
        step("R10", 0, 1, 0, 1, 0, 0, 1, 0);
        step("R10", 0, 1, 0, 1, 0, 0, 1, 1);
        chk(hs_req == 0, "R10", hs_req, 0);
        // R4 with the lower comparator high on the eighth sample
        step("R10", 0, 1, 0, 1, 0, 0, 1, 0);
        for (int i = 0; i < 7; i++) step("R4", 1, 0, 0, 1, 0, 0, 0, 0);
        step("R4", 1, 0, 0, 1, 0, 0, 1, 0);
        step("R4", 0, 0, 0, 1, 0, 0, 0, 0);
        chk(mode_hys == 0 && hs_req == 0, "R4", {mode_hys, hs_req}, 0);
        // R6: strap drops hysteretic mode
        run_samples("R3", 8, 1);
        step("R6", 0, 1, 1, 1, 0, 0, 0, 0);
        step("R6", 0, 1, 0, 1, 0, 0, 0, 0);
        chk(mode_hys == 0, "R6", mode_hys, 0);
        // R6: eighth sample coincides with strap
        run_samples("R6", 7, 1);
        step("R6", 1, 1, 1, 1, 0, 0, 0, 0);
        run_samples("R6", 7, 1);
        chk(mode_hys == 0, "R6", mode_hys, 0);
        // R7: soft-start not finished
        run_samples("R7", 1, 1);
        run_samples("R7", 8, 1);
        step("R7", 1, 1, 0, 0, 0, 0, 0, 0);
        step("R7", 0, 1, 0, 1, 0, 0, 0, 0);
        chk(mode_hys == 0, "R7", mode_hys, 0);
        // R8: channel 0 in memory mode is free, tracking channel is not
        for (int i = 0; i < 8; i++) step("R8", 1, 1, 0, 1, 1, 0, 0, 0);
        step("R8", 0, 1, 0, 1, 1, 0, 0, 0);
        chk(mode_hys == 1, "R8", mode_hys, 1);
        step("R8", 0, 1, 0, 1, 1, 1, 0, 0);
        for (int i = 0; i < 10; i++) step("R8", 1, 1, 0, 1, 1, 1, 1, 0);
        chk(mode_hys == 0, "R8", mode_hys, 0);

        // random phase
        regime = 0;
        for (int i = 0; i < 4000; i++) begin
            bit st, sg, fc, ssd, ddr, ch;
            if ($urandom_range(39) == 0) regime = !regime;
            st  = ($urandom_range(2) == 0);
            sg  = ($urandom_range(9) == 0) ? !regime : regime;
            fc  = ($urandom_range(59) == 0);
            ssd = ($urandom_range(79) != 0);
            ddr = ($urandom_range(3) == 0);
            ch  = $urandom_range(1);
            step("R2 R3 R4 R5", st, sg, fc, ssd, ddr, ch,
                 ($urandom_range(3) == 0), ($urandom_range(3) == 0));
        end
        compare("R5");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule